// File: doc/BRIEF.md
# Opcode Control Decoder

This block is the combinational control unit of a small single-cycle core whose instructions carry a 4-bit operation code in their top nibble. There is no separate function field. The one code alone picks between register-to-register arithmetic, immediate arithmetic, a load of a constant and two conditional branches. From that code the block produces a control bundle:

- an ALU operation select;
- an operand-B source select, which chooses the second register or the 4-bit immediate;
- a register write enable;
- a branch flag;
- a branch polarity bit;
- a load-immediate flag, so that write-back can take the raw immediate.

The block has no state. It first sorts the code into an instruction class: register ALU, load-immediate, add-immediate, branch-if-zero, branch-if-nonzero, or no-operation. It then encodes the bundle from that class. The branch-taken test is left to the datapath, as `branch AND (zero XOR polarity)`, where `zero` is true when the tested register reads zero.

The ALU select encoding is: ADD=000, SUB=001, AND=010, OR=011, SLT=100.

Top module: `opcode_ctl_decoder`

## Requirements
- R1: Codes 0000, 0001, 0010, 0011 and 0100 give `alu_sel_o` = 000, 001, 010, 011 and 100 respectively, with `alu_src_o`=0, `reg_write_o`=1, `branch_o`=0 and `load_imm_o`=0.
- R2: Code 0110 (load constant) gives `alu_src_o`=1, `reg_write_o`=1 and `branch_o`=0.
- R3: Code 0111 (add immediate) gives `alu_src_o`=1, `reg_write_o`=1, `alu_sel_o`=000 (ADD) and `load_imm_o`=0.
- R4: Codes 1000 (branch if zero) and 1001 (branch if nonzero) give `branch_o`=1, `reg_write_o`=0 and `alu_src_o`=0.
- R5: `br_ne_o` is 1 only for code 1001 and 0 for all other codes. As a result, `branch_o & (zero ^ br_ne_o)` is true exactly when 1000 sees a zero register or 1001 sees a nonzero one.
- R6: `branch_o` is 0 for every code other than 1000 and 1001.
- R7: Codes 0101 and 1010 through 1111 are no-operations: `reg_write_o`=0, `branch_o`=0, `alu_src_o`=0 and `load_imm_o`=0.
- R8: `load_imm_o` is 1 for code 0110 only.
- R9: `alu_sel_o` is 000 (ADD) for every code from 0101 through 1111.
- R10: Every output has a known 0/1 value for each of the 16 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 4 | Operation code taken from the top nibble of the instruction |
| alu_sel_o | output | 3 | ALU operation select (ADD=000, SUB=001, AND=010, OR=011, SLT=100) |
| alu_src_o | output | 1 | Operand-B source: 0 selects the second register, 1 selects the immediate |
| reg_write_o | output | 1 | Register file write enable |
| branch_o | output | 1 | The instruction is a conditional branch |
| br_ne_o | output | 1 | Branch polarity: 0 branches on zero, 1 branches on nonzero |
| load_imm_o | output | 1 | Write-back takes the raw immediate |

## Verification
The assertions expect the opcode to hold a known two-state value whenever the decode is evaluated. They also expect the class produced by the classifier to be one of the six defined classes. The stimulus meets both conditions by driving every one of the 16 codes as a full 4-bit value on the inactive clock edge, and it samples the outputs half a period later. The sweep repeats in ascending and descending order, so every change from one code to the next is seen in both directions. This exposes any output that still holds the value of the previous code.

// File: rtl/opc_ctl_pkg.sv
package opc_ctl_pkg;

    localparam int OPC_W     = 4;
    localparam int ALU_SEL_W = 3;
    localparam int NUM_OPC   = 1 << OPC_W;

    typedef enum logic [ALU_SEL_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_RALU = 3'd0,
        CLS_LDI  = 3'd1,
        CLS_ADDI = 3'd2,
        CLS_BEQZ = 3'd3,
        CLS_BNEZ = 3'd4,
        CLS_NOP  = 3'd5
    } instr_cls_e;

    typedef struct packed {
        alu_op_e alu_sel;
        logic    alu_src;
        logic    reg_write;
        logic    branch;
        logic    br_ne;
        logic    load_imm;
    } ctl_bundle_t;

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_OR   = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_SLT  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_LDI  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_ADDI = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_BEQZ = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_BNEZ = 4'b1001;

endpackage

// File: rtl/opc_classify.sv
module opc_classify
    import opc_ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output instr_cls_e       cls_o,
    output alu_op_e          rop_o
);

    always_comb begin
        cls_o = CLS_NOP;
        rop_o = ALU_ADD;
        unique case (opcode_i)
            OPC_ADD: begin
                cls_o = CLS_RALU;
                rop_o = ALU_ADD;
            end
            OPC_SUB: begin
                cls_o = CLS_RALU;
                rop_o = ALU_SUB;
            end
            OPC_AND: begin
                cls_o = CLS_RALU;
                rop_o = ALU_AND;
            end
            OPC_OR: begin
                cls_o = CLS_RALU;
                rop_o = ALU_OR;
            end
            OPC_SLT: begin
                cls_o = CLS_RALU;
                rop_o = ALU_SLT;
            end
            OPC_LDI:  cls_o = CLS_LDI;
            OPC_ADDI: cls_o = CLS_ADDI;
            OPC_BEQZ: cls_o = CLS_BEQZ;
            OPC_BNEZ: cls_o = CLS_BNEZ;
            default: begin
                cls_o = CLS_NOP;
                rop_o = ALU_ADD;
            end
        endcase

        // R7
        nop_class_chk: assert (cls_o != CLS_NOP || rop_o == ALU_ADD);
    end

endmodule

// File: rtl/opc_ctl_encode.sv
module opc_ctl_encode
    import opc_ctl_pkg::*;
(
    input  instr_cls_e  cls_i,
    input  alu_op_e     rop_i,
    output ctl_bundle_t ctl_o
);

    always_comb begin
        ctl_o = '{alu_sel: ALU_ADD, alu_src: 1'b0, reg_write: 1'b0,
                  branch: 1'b0, br_ne: 1'b0, load_imm: 1'b0};
        unique case (cls_i)
            CLS_RALU: begin
                ctl_o.alu_sel   = rop_i;
                ctl_o.reg_write = 1'b1;
            end
            CLS_LDI: begin
                ctl_o.alu_src   = 1'b1;
                ctl_o.reg_write = 1'b1;
                ctl_o.load_imm  = 1'b1;
            end
            CLS_ADDI: begin
                ctl_o.alu_src   = 1'b1;
                ctl_o.reg_write = 1'b1;
            end
            CLS_BEQZ: begin
                ctl_o.branch = 1'b1;
            end
            CLS_BNEZ: begin
                ctl_o.branch = 1'b1;
                ctl_o.br_ne  = 1'b1;
            end
            default: begin
                ctl_o.alu_sel = ALU_ADD;
            end
        endcase

        // R4
        branch_no_write_chk: assert (!(ctl_o.branch && ctl_o.reg_write));
        // R5
        polarity_needs_branch_chk: assert (!ctl_o.br_ne || ctl_o.branch);
        // R8
        loadimm_uses_imm_chk: assert (!ctl_o.load_imm || (ctl_o.alu_src && ctl_o.reg_write));
        // R1
        ralu_reg_operand_chk: assert (cls_i != CLS_RALU || (ctl_o.reg_write && !ctl_o.alu_src));
        // R10
        known_out_chk: assert (!$isunknown(ctl_o));
    end

endmodule

// File: rtl/opcode_ctl_decoder.sv
module opcode_ctl_decoder
    import opc_ctl_pkg::*;
(
    input  logic [OPC_W-1:0]     opcode_i,
    output logic [ALU_SEL_W-1:0] alu_sel_o,
    output logic                 alu_src_o,
    output logic                 reg_write_o,
    output logic                 branch_o,
    output logic                 br_ne_o,
    output logic                 load_imm_o
);

    instr_cls_e  cls;
    alu_op_e     rop;
    ctl_bundle_t ctl;

    opc_classify u_classify (
        .opcode_i (opcode_i),
        .cls_o    (cls),
        .rop_o    (rop)
    );

    opc_ctl_encode u_encode (
        .cls_i (cls),
        .rop_i (rop),
        .ctl_o (ctl)
    );

    assign alu_sel_o   = ctl.alu_sel;
    assign alu_src_o   = ctl.alu_src;
    assign reg_write_o = ctl.reg_write;
    assign branch_o    = ctl.branch;
    assign br_ne_o     = ctl.br_ne;
    assign load_imm_o  = ctl.load_imm;

endmodule

// File: tb/opcode_ctl_decoder_test.sv
`timescale 1ns/1ps
module opcode_ctl_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode;
    logic [2:0] alu_sel;
    logic       alu_src, reg_write, branch, br_ne, load_imm;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    opcode_ctl_decoder uut (
        .opcode_i    (opcode),
        .alu_sel_o   (alu_sel),
        .alu_src_o   (alu_src),
        .reg_write_o (reg_write),
        .branch_o    (branch),
        .br_ne_o     (br_ne),
        .load_imm_o  (load_imm)
    );

    task automatic chk(input string req, input int o, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s opcode=%0d actual=%0d expected=%0d", req, o, act, exp);
        end
    endtask

    task automatic check_code(input int o);
        int e_sel, e_src, e_wr, e_br, e_ne, e_li;
        e_wr  = (o <= 4 || o == 6 || o == 7) ? 1 : 0;
        e_src = (o == 6 || o == 7) ? 1 : 0;
        e_br  = (o == 8 || o == 9) ? 1 : 0;
        e_ne  = (o == 9) ? 1 : 0;
        e_li  = (o == 6) ? 1 : 0;
        e_sel = (o <= 4) ? o : 0;
        @(negedge clk);
        opcode = o[3:0];
        @(posedge clk);
        #1;
        if (o <= 4) begin
            chk("R1 alu_sel", o, int'(alu_sel), e_sel);
            chk("R1 alu_src", o, int'(alu_src), e_src);
            chk("R1 reg_write", o, int'(reg_write), e_wr);
        end else if (o == 6) begin
            chk("R2 alu_src", o, int'(alu_src), e_src);
            chk("R2 reg_write", o, int'(reg_write), e_wr);
        end else if (o == 7) begin
            chk("R3 alu_src", o, int'(alu_src), e_src);
            chk("R3 reg_write", o, int'(reg_write), e_wr);
        end else if (o == 8 || o == 9) begin
            chk("R4 reg_write", o, int'(reg_write), e_wr);
            chk("R4 alu_src", o, int'(alu_src), e_src);
        end else begin
            chk("R7 reg_write", o, int'(reg_write), e_wr);
            chk("R7 alu_src", o, int'(alu_src), e_src);
        end
        if (o > 4)
            chk("R9 alu_sel", o, int'(alu_sel), e_sel);
        chk("R6 branch", o, int'(branch), e_br);
        chk("R5 br_ne", o, int'(br_ne), e_ne);
        chk("R8 load_imm", o, int'(load_imm), e_li);
        for (int z = 0; z < 2; z++) begin
            int e_taken;
            e_taken = ((o == 8 && z == 1) || (o == 9 && z == 0)) ? 1 : 0;
            chk("R5 taken", o, int'(branch & (z[0] ^ br_ne)), e_taken);
        end
        chk("R10 known", o, int'($isunknown({alu_sel, alu_src, reg_write, branch, br_ne, load_imm})), 0);
    endtask

    initial begin
        opcode = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset alu_sel", 0, int'(alu_sel), 0);
        chk("R1 reset reg_write", 0, int'(reg_write), 1);
        @(negedge clk);
        rst = 1'b0;
        for (int o = 0; o < 16; o++) check_code(o);
        for (int o = 15; o >= 0; o--) check_code(o);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule